// File: doc/BRIEF.md
# Numeric Coprocessor Interface Glue

This block sits between a 16-bit processor and its numeric coprocessor. It decodes the coprocessor's I/O window into a chip select, forwards the coprocessor's busy line to the processor, and freezes that busy line when the coprocessor reports an error. A frozen busy is paired with an interrupt request, so the processor stays stalled and software is told to service the fault.

Software releases the frozen state by writing to either of two clear ports. One of those ports also starts a software reset of the coprocessor: a reset pulse of a fixed number of clocks. A system reset clears the error state and holds the coprocessor reset for as long as it lasts. All inputs are sampled on the block clock. A write acts once, in the cycle where the write strobe is first seen high.

Top module: `fpu_glue`

## Requirements
- R1: `cpSel` is high in the same cycle whenever `ioRd` or `ioWr` is high and `ioAddr` lies in 0x00F8..0x00FF, with every upper address bit zero. It is low for any other address, and low when neither strobe is high.
- R2: While no error is latched, `cpuBusy` equals `cpBusyIn` in the same cycle.
- R3: If `cpErrIn` and `cpBusyIn` are both high at a clock edge, then from that edge `cpIrq` is high and `cpuBusy` is held high, even after `cpBusyIn` falls.
- R4: The latched error (`cpIrq` and the held `cpuBusy`) clears only at the edge that sees a write rising edge to port 0x00F0 or 0x00F1. Writes to other ports, including 0x00F8, leave it set.
- R5: While `rstSys` is high, `cpReset` is high. The edge that sees `rstSys` clears the error latch and cancels any software reset pulse in progress.
- R6: A write rising edge to port 0x00F1 drives `cpReset` high for exactly RST_LEN clocks (default 4), starting at that edge. A write to 0x00F0 leaves `cpReset` low.
- R7: An error input seen while `cpBusyIn` is low does not set the latch.
- R8: A write acts only in the first cycle of `ioWr` high (its rising edge as sampled). A strobe held high for many cycles acts once, so the reset pulse still ends after RST_LEN clocks.
- R9: When a new error (`cpErrIn` and `cpBusyIn` high) coincides with a clearing write, setting wins and `cpIrq` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstSys | input | 1 | System reset, active high, synchronous |
| ioAddr | input | 16 | I/O address |
| ioRd | input | 1 | I/O read strobe, active high |
| ioWr | input | 1 | I/O write strobe, active high |
| cpBusyIn | input | 1 | Busy from the coprocessor, active high |
| cpErrIn | input | 1 | Error from the coprocessor, active high |
| cpSel | output | 1 | Coprocessor chip select |
| cpuBusy | output | 1 | Busy to the processor |
| cpIrq | output | 1 | Coprocessor error interrupt request |
| cpReset | output | 1 | Coprocessor reset |

## Verification
The assertions assume that the strobes, address and coprocessor lines are synchronous to the block clock. They also assume that a write strobe falls between writes, so two rising edges cannot occur in consecutive cycles. The bench changes every input one time unit after a rising edge and samples outputs there as well. Each write drops `ioWr` for at least one cycle before the next, except in the deliberately held-strobe test.

// File: rtl/fpu_glue_pkg.sv
package fpu_glue_pkg;
  // strobes passed from the decode/control side to the state side
  typedef struct packed {
    logic wrEdge;   // first cycle of a write
    logic clrErr;   // write to either clear port
    logic swReset;  // write to the reset port
  } ctlStrb_t;
endpackage

// File: rtl/fpu_glue_ctl.sv
module fpu_glue_ctl
  import fpu_glue_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SEL_BASE      = 'hF8,
  parameter int SEL_SPAN_LOG2 = 3,
  parameter int CLR_PORT      = 'hF0,
  parameter int RST_PORT      = 'hF1
) (
  input  logic              clk,
  input  logic              rstSys,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  output logic              cpSel,
  output ctlStrb_t          strb
);
  localparam logic [ADDR_W-1:0] SEL_FULL = ADDR_W'(SEL_BASE);
  localparam logic [ADDR_W-1:0] CLR_FULL = ADDR_W'(CLR_PORT);
  localparam logic [ADDR_W-1:0] RST_FULL = ADDR_W'(RST_PORT);

  logic wrPrev;
  logic inWindow;

  always_ff @(posedge clk) begin
    if (rstSys) wrPrev <= 1'b0;
    else        wrPrev <= ioWr;
  end

  assign inWindow = (ioAddr[ADDR_W-1:SEL_SPAN_LOG2] == SEL_FULL[ADDR_W-1:SEL_SPAN_LOG2]);
  assign cpSel    = inWindow && (ioRd || ioWr);

  always_comb begin
    strb.wrEdge  = ioWr && !wrPrev;
    strb.swReset = strb.wrEdge && (ioAddr == RST_FULL);
    strb.clrErr  = strb.wrEdge && ((ioAddr == CLR_FULL) || (ioAddr == RST_FULL));
  end

  // R8: a write edge cannot repeat in the next cycle
  assert_single_edge_R8: assert property (@(posedge clk) disable iff (rstSys)
    strb.wrEdge |=> !strb.wrEdge);
  // R6: a reset request is always also a clearing write
  assert_reset_clears_R6: assert property (@(posedge clk) disable iff (rstSys)
    strb.swReset |-> strb.clrErr);
endmodule

// File: rtl/fpu_glue_dp.sv
module fpu_glue_dp
  import fpu_glue_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic     clk,
  input  logic     rstSys,
  input  ctlStrb_t strb,
  input  logic     cpBusyIn,
  input  logic     cpErrIn,
  output logic     cpuBusy,
  output logic     cpIrq,
  output logic     cpReset
);
  localparam int CNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_LEN);

  logic             errLatch;
  logic             errSeen;
  logic [CNT_W-1:0] rstCnt;

  assign errSeen = cpErrIn && cpBusyIn;

  always_ff @(posedge clk) begin
    if (rstSys)            errLatch <= 1'b0;
    else if (errSeen)      errLatch <= 1'b1;
    else if (strb.clrErr)  errLatch <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rstSys)              rstCnt <= '0;
    else if (strb.swReset)   rstCnt <= CNT_LOAD;
    else if (rstCnt != '0)   rstCnt <= rstCnt - 1'b1;
  end

  assign cpuBusy = cpBusyIn || errLatch;
  assign cpIrq   = errLatch;
  assign cpReset = rstSys || (rstCnt != '0);

  // R3: an error during busy raises the interrupt at the next edge
  assert_err_sets_R3: assert property (@(posedge clk) disable iff (rstSys)
    (cpErrIn && cpBusyIn) |=> cpIrq);
  // R4: the interrupt holds unless a clearing write arrives
  assert_irq_holds_R4: assert property (@(posedge clk) disable iff (rstSys)
    (cpIrq && !strb.clrErr) |=> cpIrq);
  // R7: the interrupt only rises after an error seen during busy
  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (rstSys)
    $rose(cpIrq) |-> $past(cpErrIn && cpBusyIn));
  // R6: a reset request yields a coprocessor reset
  assert_sw_reset_R6: assert property (@(posedge clk) disable iff (rstSys)
    strb.swReset |=> cpReset);
  // R5: system reset leaves no interrupt behind
  assert_sys_clear_R5: assert property (@(posedge clk)
    rstSys |=> !cpIrq);
endmodule

// File: rtl/fpu_glue.sv
module fpu_glue
  import fpu_glue_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SEL_BASE      = 'hF8,
  parameter int SEL_SPAN_LOG2 = 3,
  parameter int CLR_PORT      = 'hF0,
  parameter int RST_PORT      = 'hF1,
  parameter int RST_LEN       = 4
) (
  input  logic              clk,
  input  logic              rstSys,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              cpBusyIn,
  input  logic              cpErrIn,
  output logic              cpSel,
  output logic              cpuBusy,
  output logic              cpIrq,
  output logic              cpReset
);
  ctlStrb_t strb;

  fpu_glue_ctl #(
    .ADDR_W(ADDR_W), .SEL_BASE(SEL_BASE), .SEL_SPAN_LOG2(SEL_SPAN_LOG2),
    .CLR_PORT(CLR_PORT), .RST_PORT(RST_PORT)
  ) u_ctl (
    .clk(clk), .rstSys(rstSys), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .cpSel(cpSel), .strb(strb)
  );

  fpu_glue_dp #(.RST_LEN(RST_LEN)) u_dp (
    .clk(clk), .rstSys(rstSys), .strb(strb), .cpBusyIn(cpBusyIn),
    .cpErrIn(cpErrIn), .cpuBusy(cpuBusy), .cpIrq(cpIrq), .cpReset(cpReset)
  );
endmodule

// File: tb/fpu_glue_tb.sv
module fpu_glue_tb;
  localparam int RST_LEN = 4;

  logic clk = 1'b0;
  logic rstSys = 1'b1;
  logic [15:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0, cpBusyIn = 1'b0, cpErrIn = 1'b0;
  logic cpSel, cpuBusy, cpIrq, cpReset;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fpu_glue #(.RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rstSys(rstSys), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .cpBusyIn(cpBusyIn), .cpErrIn(cpErrIn), .cpSel(cpSel), .cpuBusy(cpuBusy),
    .cpIrq(cpIrq), .cpReset(cpReset)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic rd, wr, busy, expSel, expBusy;
  } vec_t;

  // R1 / R2 vectors: address, rd, wr, busy in, expected select, expected busy
  localparam vec_t VECS [10] = '{
    '{16'h00F7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h00F8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h00FC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{16'h00FA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h01F8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h00FE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writePort(input logic [15:0] a);
    ioAddr = a;
    ioWr = 1'b1;
    step();
    ioWr = 1'b0;
  endtask

  task automatic raiseErr();
    cpBusyIn = 1'b1; cpErrIn = 1'b1;
    step();
    cpBusyIn = 1'b0; cpErrIn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    // R5: reset state
    check("R5 reset holds cpReset", cpReset, 1'b1);
    check("R5 reset irq", cpIrq, 1'b0);
    rstSys = 1'b0;
    step();
    check("R5 cpReset after release", cpReset, 1'b0);

    // R1, R2: table walk
    for (int i = 0; i < 10; i++) begin
      ioAddr = VECS[i].addr; ioRd = VECS[i].rd; ioWr = VECS[i].wr;
      cpBusyIn = VECS[i].busy;
      #1;
      check("R1 select decode", cpSel, VECS[i].expSel);
      check("R2 busy passthrough", cpuBusy, VECS[i].expBusy);
      step();
    end
    ioRd = 1'b0; ioWr = 1'b0; cpBusyIn = 1'b0;
    step();

    // R7: error without busy
    cpErrIn = 1'b1;
    step();
    cpErrIn = 1'b0;
    check("R7 no latch without busy", cpIrq, 1'b0);
    check("R7 busy stays low", cpuBusy, 1'b0);

    // R3: error during busy
    raiseErr();
    check("R3 irq raised", cpIrq, 1'b1);
    check("R3 busy held after input falls", cpuBusy, 1'b1);

    // R4: non-clearing write, held two cycles
    ioAddr = 16'h00F8; ioWr = 1'b1;
    step(); step();
    ioWr = 1'b0;
    step();
    check("R4 write to F8 leaves irq", cpIrq, 1'b1);
    writePort(16'h00F0);
    check("R4 write F0 clears irq", cpIrq, 1'b0);
    check("R4 write F0 releases busy", cpuBusy, 1'b0);
    check("R6 write F0 no reset", cpReset, 1'b0);
    step();

    // R6: reset port clears error and pulses reset
    raiseErr();
    writePort(16'h00F1);
    check("R4 write F1 clears irq", cpIrq, 1'b0);
    for (int k = 0; k < RST_LEN; k++) begin
      check("R6 reset pulse high", cpReset, 1'b1);
      step();
    end
    check("R6 reset pulse ends", cpReset, 1'b0);

    // R8: held write strobe acts once
    ioAddr = 16'h00F1; ioWr = 1'b1;
    step();
    for (int k = 0; k < RST_LEN; k++) begin
      check("R8 pulse while strobe held", cpReset, 1'b1);
      step();
    end
    check("R8 pulse ends with strobe held", cpReset, 1'b0);
    step();
    check("R8 no retrigger", cpReset, 1'b0);
    ioWr = 1'b0;
    step();

    // R9: set wins over clear
    raiseErr();
    cpBusyIn = 1'b1; cpErrIn = 1'b1;
    writePort(16'h00F0);
    cpBusyIn = 1'b0; cpErrIn = 1'b0;
    check("R9 set beats clear", cpIrq, 1'b1);
    step();
    writePort(16'h00F0);
    check("R9 later clear works", cpIrq, 1'b0);
    step();

    // R5: system reset clears latch and cancels pulse
    raiseErr();
    ioAddr = 16'h00F1; ioWr = 1'b1;
    cpBusyIn = 1'b1; cpErrIn = 1'b1;
    step();
    ioWr = 1'b0; cpBusyIn = 1'b0; cpErrIn = 1'b0;
    check("R9 irq kept with reset write", cpIrq, 1'b1);
    rstSys = 1'b1;
    step();
    check("R5 reset clears irq", cpIrq, 1'b0);
    check("R5 cpReset during reset", cpReset, 1'b1);
    rstSys = 1'b0;
    step();
    check("R5 pulse cancelled", cpReset, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule